// File: doc/BRIEF.md
# Memory Traffic Exerciser with Read-Back Checker

This block drives an external memory through a burst-capable memory-mapped master port, writing a deterministic data stream and then reading the same locations back to verify them. Software programs it through a small word-addressed register file. Each loop issues a set number of write bursts, then a set number of read bursts over the same addresses. Every read beat is compared against data regenerated from the same seed.

The register file sets the burst length, the address stride, the data pattern, the seed and the loop count. Results are reported as a sticky error flag, a saturating mismatch count, the address of the first failing beat and a cycle count for the whole run. Bandwidth follows from that cycle count. The test runs either a fixed number of loops or continuously, until software drops the run bit. In continuous mode the loop that is in progress completes before the block stops.

Top module: `mem_exerciser`

## Requirements
- R1: After reset the identification word (offset 0) reads the `GEN_ID` parameter. The defaults are: write count 1 (offset 3), read count 1 (offset 4), burst 1 (offset 5), stride 1 (offset 6), pattern 0 (offset 7), loop count 1 (offset 8). Status (offset 2) reads 0.
- R2: The burst register accepts only the values 1, 2, 4, 8 and 16. A write of any other value leaves the previous value in place.
- R3: Within a loop, transaction i starts at word address i*stride*burst. The beats of a burst cover consecutive addresses, and the address is held for the whole burst.
- R4: Pattern codes are 0 fixed, 1 PRBS7, 2 PRBS15, 3 PRBS31 and 4 rotate-left-by-one. A code of 5 or more is ignored. The first beat is the seed masked to the generator width (7, 15, 31 or 32 bits); for a PRBS pattern a zero result becomes 1. Each following beat is one step of that generator:
  - PRBS7 shifts in s6^s5.
  - PRBS15 shifts in s14^s13.
  - PRBS31 shifts in s30^s27.
  - Fixed repeats the seed.
- R5: The read phase compares every returned beat with the regenerated stream. When memory holds what was written, the error flag (status bit 2) and the mismatch count (offset 10) stay 0.
- R6: A mismatch sets the sticky error flag and increments the mismatch count, which saturates at 2^ERR_W-1. The word address of the first failing beat is kept at offset 11.
- R7: In non-continuous mode the block runs max(1, loop count) loops. Each loop has write-count write bursts, then read-count read bursts. Status bit 1 (done) is then set and status bit 0 (busy) clears.
- R8: Continuous mode (control bit 1) ignores the loop count. It repeats whole loops until control bit 0 (run) is written 0, then finishes the current loop.
- R9: The cycle count (offset 12) increments on every busy cycle, holds its value once the run ends, and restarts from 0 at each start. A run with one write and one read of one beat, answered one cycle after the read is accepted, counts 5.
- R10: A request stays asserted, with stable address and data, while wait-request is high. Only accepted beats advance the stream.
- R11: Writing control bit 0 as 1 while idle starts a run. The start clears done, the error flag, the mismatch count and the failing address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 4 | Register word offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data (combinational from csr_addr) |
| mm_addr | output | ADDR_W | Burst start word address |
| mm_write | output | 1 | Write request, one per beat |
| mm_read | output | 1 | Read burst request |
| mm_burst | output | 5 | Beats per burst |
| mm_wdata | output | 32 | Write beat data |
| mm_waitreq | input | 1 | Memory stalls the current request |
| mm_rvalid | input | 1 | Read beat valid |
| mm_rdata | input | 32 | Read beat data |

## Verification
The hardest conditions to reach from the ports are a mismatch count at saturation, and a stop request that lands in the middle of a continuous loop. To reach saturation, the memory model inverts every returned beat across 20 bursts of 16 beats, which gives 320 mismatches. For the stop, the model counts accepted write bursts and drops the run bit only after several loops have gone by. The bench then checks that read bursts equal whole loops times the read count. A mismatch on one chosen beat index pins down the failing address. A pseudo-random wait-request and read-valid gap pattern puts stalls on both request kinds.

// File: rtl/mx_pkg.sv
package mx_pkg;

    localparam int DW      = 32;
    localparam int BURST_W = 5;
    localparam int CA_W    = 4;

    typedef enum logic [2:0] {
        PAT_FIXED  = 3'd0,
        PAT_PRBS7  = 3'd1,
        PAT_PRBS15 = 3'd2,
        PAT_PRBS31 = 3'd3,
        PAT_ROT1   = 3'd4
    } pat_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOOP, ST_WR, ST_RDREQ, ST_RDDAT, ST_LEND
    } st_e;

    localparam logic [CA_W-1:0] A_ID     = 4'd0;
    localparam logic [CA_W-1:0] A_CTRL   = 4'd1;
    localparam logic [CA_W-1:0] A_STAT   = 4'd2;
    localparam logic [CA_W-1:0] A_WRCNT  = 4'd3;
    localparam logic [CA_W-1:0] A_RDCNT  = 4'd4;
    localparam logic [CA_W-1:0] A_BURST  = 4'd5;
    localparam logic [CA_W-1:0] A_STRIDE = 4'd6;
    localparam logic [CA_W-1:0] A_PAT    = 4'd7;
    localparam logic [CA_W-1:0] A_LOOPS  = 4'd8;
    localparam logic [CA_W-1:0] A_SEED   = 4'd9;
    localparam logic [CA_W-1:0] A_ERRS   = 4'd10;
    localparam logic [CA_W-1:0] A_FAIL   = 4'd11;
    localparam logic [CA_W-1:0] A_CYC    = 4'd12;

    // First beat of a stream: seed cut to the generator width, PRBS never zero.
    function automatic logic [DW-1:0] pat_first(pat_e p, logic [DW-1:0] seed);
        logic [DW-1:0] s;
        case (p)
            PAT_PRBS7:  s = {25'd0, seed[6:0]};
            PAT_PRBS15: s = {17'd0, seed[14:0]};
            PAT_PRBS31: s = {1'b0, seed[30:0]};
            default:    s = seed;
        endcase
        if (s == '0 && (p == PAT_PRBS7 || p == PAT_PRBS15 || p == PAT_PRBS31))
            s = {{(DW-1){1'b0}}, 1'b1};
        return s;
    endfunction

    // One generator step.
    function automatic logic [DW-1:0] pat_next(pat_e p, logic [DW-1:0] s);
        case (p)
            PAT_PRBS7:  return {25'd0, s[5:0], s[6] ^ s[5]};
            PAT_PRBS15: return {17'd0, s[13:0], s[14] ^ s[13]};
            PAT_PRBS31: return {1'b0, s[29:0], s[30] ^ s[27]};
            PAT_ROT1:   return {s[DW-2:0], s[DW-1]};
            default:    return s;
        endcase
    endfunction

    function automatic logic burst_legal(logic [DW-1:0] v);
        return (v == 32'd1) || (v == 32'd2) || (v == 32'd4) ||
               (v == 32'd8) || (v == 32'd16);
    endfunction

endpackage

// File: rtl/mx_patgen.sv
module mx_patgen
    import mx_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          adv,
    input  pat_e          pat,
    input  logic [DW-1:0] seed,
    output logic [DW-1:0] data
);

    typedef struct packed {
        logic [DW-1:0] st;
    } pg_s;

    pg_s pg_d, pg_q;

    always_comb begin
        pg_d = pg_q;
        if (load)
            pg_d.st = pat_first(pat, seed);
        else if (adv)
            pg_d.st = pat_next(pat, pg_q.st);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pg_q <= '0;
        else        pg_q <= pg_d;
    end

    assign data = pg_q.st;

    AST_PRBS_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && $stable(pat) && pg_q.st != '0 &&
         (pat == PAT_PRBS7 || pat == PAT_PRBS15 || pat == PAT_PRBS31)) |=> pg_q.st != '0); // R4

endmodule

// File: rtl/mx_csr.sv
module mx_csr
    import mx_pkg::*;
#(
    parameter logic [DW-1:0] GEN_ID = 32'h7E57_0A01,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int ERR_W  = 8,
    parameter int CYC_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [CA_W-1:0]    addr,
    input  logic [DW-1:0]      wdata,
    output logic [DW-1:0]      rdata,
    input  logic               busy,
    input  logic               done,
    input  logic               err,
    input  logic [ERR_W-1:0]   errs,
    input  logic [ADDR_W-1:0]  fail_addr,
    input  logic [CYC_W-1:0]   cycles,
    input  logic               finish,
    output logic               start,
    output logic               run,
    output logic               cont,
    output logic [CNT_W-1:0]   wrcnt,
    output logic [CNT_W-1:0]   rdcnt,
    output logic [BURST_W-1:0] burst,
    output logic [CNT_W-1:0]   stride,
    output pat_e               pat,
    output logic [CNT_W-1:0]   loops,
    output logic [DW-1:0]      seed
);

    typedef struct packed {
        logic               run;
        logic               cont;
        logic [CNT_W-1:0]   wrcnt;
        logic [CNT_W-1:0]   rdcnt;
        logic [BURST_W-1:0] burst;
        logic [CNT_W-1:0]   stride;
        pat_e               pat;
        logic [CNT_W-1:0]   loops;
        logic [DW-1:0]      seed;
    } csr_s;

    localparam csr_s CSR_RST = '{
        run: 1'b0, cont: 1'b0,
        wrcnt: CNT_W'(1), rdcnt: CNT_W'(1),
        burst: BURST_W'(1), stride: CNT_W'(1),
        pat: PAT_FIXED, loops: CNT_W'(1),
        seed: 32'hA5A5_5A5A
    };

    csr_s csr_d, csr_q;

    always_comb begin
        csr_d = csr_q;
        start = 1'b0;
        if (wr) begin
            case (addr)
                A_CTRL: begin
                    csr_d.cont = wdata[1];
                    if (!wdata[0])
                        csr_d.run = 1'b0;
                    else if (!busy) begin
                        csr_d.run = 1'b1;
                        start     = 1'b1;
                    end
                end
                A_WRCNT:  csr_d.wrcnt  = wdata[CNT_W-1:0];
                A_RDCNT:  csr_d.rdcnt  = wdata[CNT_W-1:0];
                A_BURST:  if (burst_legal(wdata)) csr_d.burst = wdata[BURST_W-1:0];
                A_STRIDE: csr_d.stride = wdata[CNT_W-1:0];
                A_PAT:    if (wdata < 32'd5) csr_d.pat = pat_e'(wdata[2:0]);
                A_LOOPS:  csr_d.loops  = wdata[CNT_W-1:0];
                A_SEED:   csr_d.seed   = wdata;
                default: ;
            endcase
        end
        if (finish)
            csr_d.run = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) csr_q <= CSR_RST;
        else        csr_q <= csr_d;
    end

    always_comb begin
        case (addr)
            A_ID:     rdata = GEN_ID;
            A_CTRL:   rdata = {30'd0, csr_q.cont, csr_q.run};
            A_STAT:   rdata = {29'd0, err, done, busy};
            A_WRCNT:  rdata = 32'(csr_q.wrcnt);
            A_RDCNT:  rdata = 32'(csr_q.rdcnt);
            A_BURST:  rdata = 32'(csr_q.burst);
            A_STRIDE: rdata = 32'(csr_q.stride);
            A_PAT:    rdata = 32'(csr_q.pat);
            A_LOOPS:  rdata = 32'(csr_q.loops);
            A_SEED:   rdata = csr_q.seed;
            A_ERRS:   rdata = 32'(errs);
            A_FAIL:   rdata = 32'(fail_addr);
            A_CYC:    rdata = 32'(cycles);
            default:  rdata = '0;
        endcase
    end

    assign run    = csr_q.run;
    assign cont   = csr_q.cont;
    assign wrcnt  = csr_q.wrcnt;
    assign rdcnt  = csr_q.rdcnt;
    assign burst  = csr_q.burst;
    assign stride = csr_q.stride;
    assign pat    = csr_q.pat;
    assign loops  = csr_q.loops;
    assign seed   = csr_q.seed;

    AST_BURST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(csr_q.burst) == 1); // R2
    AST_PAT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        csr_q.pat <= PAT_ROT1); // R4

endmodule

// File: rtl/mx_seq.sv
module mx_seq
    import mx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int ERR_W  = 8,
    parameter int CYC_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               run,
    input  logic               cont,
    input  logic [CNT_W-1:0]   wrcnt,
    input  logic [CNT_W-1:0]   rdcnt,
    input  logic [BURST_W-1:0] burst,
    input  logic [CNT_W-1:0]   stride,
    input  logic [CNT_W-1:0]   loops,
    input  logic [DW-1:0]      wr_data,
    input  logic [DW-1:0]      exp_data,
    input  logic               mm_waitreq,
    input  logic               mm_rvalid,
    input  logic [DW-1:0]      mm_rdata,
    output logic [ADDR_W-1:0]  mm_addr,
    output logic               mm_write,
    output logic               mm_read,
    output logic               pg_load,
    output logic               adv_wr,
    output logic               adv_rd,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [ERR_W-1:0]   errs,
    output logic [ADDR_W-1:0]  fail_addr,
    output logic [CYC_W-1:0]   cycles,
    output logic               finish
);

    typedef struct packed {
        st_e                st;
        logic [CNT_W-1:0]   txn;
        logic [BURST_W-1:0] beat;
        logic [CNT_W-1:0]   loop;
        logic [ADDR_W-1:0]  addr;
        logic               done;
        logic               err;
        logic [ERR_W-1:0]   errs;
        logic               seen;
        logic [ADDR_W-1:0]  fail;
        logic [CYC_W-1:0]   cyc;
    } sq_s;

    sq_s sq_d, sq_q;

    logic [ADDR_W-1:0] step;
    logic              last_beat;
    logic [CNT_W-1:0]  next_loop;
    logic              again;

    assign step      = ADDR_W'(stride) * ADDR_W'(burst);
    assign last_beat = (sq_q.beat == burst - BURST_W'(1));
    assign next_loop = sq_q.loop + CNT_W'(1);
    assign again     = cont ? run : (next_loop < loops);

    always_comb begin
        sq_d    = sq_q;
        pg_load = 1'b0;
        adv_wr  = 1'b0;
        adv_rd  = 1'b0;
        finish  = 1'b0;
        if (sq_q.st != ST_IDLE)
            sq_d.cyc = sq_q.cyc + CYC_W'(1);
        case (sq_q.st)
            ST_IDLE: begin
                if (start) begin
                    sq_d.st   = ST_LOOP;
                    sq_d.loop = '0;
                    sq_d.done = 1'b0;
                    sq_d.err  = 1'b0;
                    sq_d.errs = '0;
                    sq_d.seen = 1'b0;
                    sq_d.fail = '0;
                    sq_d.cyc  = '0;
                end
            end
            ST_LOOP: begin
                pg_load   = 1'b1;
                sq_d.txn  = '0;
                sq_d.beat = '0;
                sq_d.addr = '0;
                if (wrcnt != '0)      sq_d.st = ST_WR;
                else if (rdcnt != '0) sq_d.st = ST_RDREQ;
                else                  sq_d.st = ST_LEND;
            end
            ST_WR: begin
                if (!mm_waitreq) begin
                    adv_wr = 1'b1;
                    if (last_beat) begin
                        sq_d.beat = '0;
                        if (sq_q.txn == wrcnt - CNT_W'(1)) begin
                            sq_d.txn  = '0;
                            sq_d.addr = '0;
                            sq_d.st   = (rdcnt != '0) ? ST_RDREQ : ST_LEND;
                        end else begin
                            sq_d.txn  = sq_q.txn + CNT_W'(1);
                            sq_d.addr = sq_q.addr + step;
                        end
                    end else begin
                        sq_d.beat = sq_q.beat + BURST_W'(1);
                    end
                end
            end
            ST_RDREQ: begin
                if (!mm_waitreq) begin
                    sq_d.st   = ST_RDDAT;
                    sq_d.beat = '0;
                end
            end
            ST_RDDAT: begin
                if (mm_rvalid) begin
                    adv_rd = 1'b1;
                    if (mm_rdata != exp_data) begin
                        sq_d.err = 1'b1;
                        if (sq_q.errs != '1)
                            sq_d.errs = sq_q.errs + ERR_W'(1);
                        if (!sq_q.seen) begin
                            sq_d.seen = 1'b1;
                            sq_d.fail = sq_q.addr + ADDR_W'(sq_q.beat);
                        end
                    end
                    if (last_beat) begin
                        sq_d.beat = '0;
                        if (sq_q.txn == rdcnt - CNT_W'(1)) begin
                            sq_d.st = ST_LEND;
                        end else begin
                            sq_d.txn  = sq_q.txn + CNT_W'(1);
                            sq_d.addr = sq_q.addr + step;
                            sq_d.st   = ST_RDREQ;
                        end
                    end else begin
                        sq_d.beat = sq_q.beat + BURST_W'(1);
                    end
                end
            end
            ST_LEND: begin
                if (again) begin
                    sq_d.loop = next_loop;
                    sq_d.st   = ST_LOOP;
                end else begin
                    sq_d.st   = ST_IDLE;
                    sq_d.done = 1'b1;
                    finish    = 1'b1;
                end
            end
            default: sq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    assign mm_addr   = sq_q.addr;
    assign mm_write  = (sq_q.st == ST_WR);
    assign mm_read   = (sq_q.st == ST_RDREQ);
    assign busy      = (sq_q.st != ST_IDLE);
    assign done      = sq_q.done;
    assign err       = sq_q.err;
    assign errs      = sq_q.errs;
    assign fail_addr = sq_q.fail;
    assign cycles    = sq_q.cyc;

    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_write && mm_waitreq) |=> (mm_write && $stable(mm_addr) && $stable(wr_data))); // R10
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_read && mm_waitreq) |=> (mm_read && $stable(mm_addr))); // R10
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.err && !start) |=> sq_q.err); // R6
    AST_ERRS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        ((&sq_q.errs) && !start) |=> (&sq_q.errs)); // R6
    AST_CYC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(sq_q.cyc)); // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.done |-> !busy); // R7
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!sq_q.done && !sq_q.err && sq_q.errs == '0)); // R11

endmodule

// File: rtl/mem_exerciser.sv
module mem_exerciser
    import mx_pkg::*;
#(
    parameter logic [31:0] GEN_ID = 32'h7E57_0A01,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16,
    parameter int ERR_W  = 8,
    parameter int CYC_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_wr,
    input  logic [3:0]        csr_addr,
    input  logic [31:0]       csr_wdata,
    output logic [31:0]       csr_rdata,
    output logic [ADDR_W-1:0] mm_addr,
    output logic              mm_write,
    output logic              mm_read,
    output logic [4:0]        mm_burst,
    output logic [31:0]       mm_wdata,
    input  logic              mm_waitreq,
    input  logic              mm_rvalid,
    input  logic [31:0]       mm_rdata
);

    localparam int N_GEN = 2;

    logic               start, run, cont, busy, done, err, finish, pg_load;
    logic [CNT_W-1:0]   wrcnt, rdcnt, stride, loops;
    logic [BURST_W-1:0] burst;
    pat_e               pat;
    logic [DW-1:0]      seed;
    logic [ERR_W-1:0]   errs;
    logic [ADDR_W-1:0]  fail_addr;
    logic [CYC_W-1:0]   cycles;
    logic [N_GEN-1:0]   pg_adv;
    logic [N_GEN-1:0][DW-1:0] pg_data;

    mx_csr #(.GEN_ID(GEN_ID), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ERR_W(ERR_W), .CYC_W(CYC_W)) u_csr (
        .clk(clk), .rst_n(rst_n), .wr(csr_wr), .addr(csr_addr), .wdata(csr_wdata),
        .rdata(csr_rdata), .busy(busy), .done(done), .err(err), .errs(errs),
        .fail_addr(fail_addr), .cycles(cycles), .finish(finish), .start(start),
        .run(run), .cont(cont), .wrcnt(wrcnt), .rdcnt(rdcnt), .burst(burst),
        .stride(stride), .pat(pat), .loops(loops), .seed(seed)
    );

    mx_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ERR_W(ERR_W), .CYC_W(CYC_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .run(run), .cont(cont),
        .wrcnt(wrcnt), .rdcnt(rdcnt), .burst(burst), .stride(stride), .loops(loops),
        .wr_data(pg_data[0]), .exp_data(pg_data[1]), .mm_waitreq(mm_waitreq),
        .mm_rvalid(mm_rvalid), .mm_rdata(mm_rdata), .mm_addr(mm_addr),
        .mm_write(mm_write), .mm_read(mm_read), .pg_load(pg_load),
        .adv_wr(pg_adv[0]), .adv_rd(pg_adv[1]), .busy(busy), .done(done), .err(err),
        .errs(errs), .fail_addr(fail_addr), .cycles(cycles), .finish(finish)
    );

    // Index 0 feeds write data, index 1 regenerates the expected read data.
    for (genvar g = 0; g < N_GEN; g++) begin : g_pat
        mx_patgen u_pg (
            .clk(clk), .rst_n(rst_n), .load(pg_load), .adv(pg_adv[g]),
            .pat(pat), .seed(seed), .data(pg_data[g])
        );
    end

    assign mm_burst = burst;
    assign mm_wdata = pg_data[0];

endmodule

// File: tb/sim_mem_exerciser.sv
module sim_mem_exerciser;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [3:0]  csr_addr = 4'd0;
    logic [31:0] csr_wdata = 32'd0;
    logic [31:0] csr_rdata;
    logic [31:0] mm_addr;
    logic        mm_write, mm_read;
    logic [4:0]  mm_burst;
    logic [31:0] mm_wdata;
    logic        mm_waitreq = 1'b0;
    logic        mm_rvalid = 1'b0;
    logic [31:0] mm_rdata = 32'd0;

    always #4 clk = ~clk;

    mem_exerciser u0 (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .mm_addr(mm_addr),
        .mm_write(mm_write), .mm_read(mm_read), .mm_burst(mm_burst),
        .mm_wdata(mm_wdata), .mm_waitreq(mm_waitreq), .mm_rvalid(mm_rvalid),
        .mm_rdata(mm_rdata)
    );

    int checks = 0;
    int errors = 0;
    int wd_cnt = 0;

    // Memory model state.
    logic [31:0] mem [0:4095];
    int  wbeat = 0, wr_bursts = 0, rd_cmds = 0, rd_left = 0, rd_ptr = 0, rb_idx = 0;
    int  corrupt_idx = -1;
    bit  corrupt_all = 1'b0, wait_mode = 1'b0;
    logic [15:0] rng = 16'hACE1;

    always @(negedge clk) begin
        rng = {rng[14:0], rng[15] ^ rng[13] ^ rng[12] ^ rng[10]};
        mm_waitreq = wait_mode && rng[0];
        mm_rvalid  = 1'b0;
        if (rd_left > 0 && !(wait_mode && rng[1])) begin
            mm_rvalid = 1'b1;
            mm_rdata  = mem[rd_ptr % 4096] ^
                        ((corrupt_all || rb_idx == corrupt_idx) ? 32'hFFFF_FFFF : 32'd0);
            rd_ptr++;
            rd_left--;
            rb_idx++;
        end
        if (mm_write === 1'b1 && !mm_waitreq) begin
            mem[(int'(mm_addr) + wbeat) % 4096] = mm_wdata;
            if (wbeat == 0) wr_bursts++;
            wbeat = (wbeat + 1 == int'(mm_burst)) ? 0 : wbeat + 1;
        end
        if (mm_read === 1'b1 && !mm_waitreq) begin
            rd_ptr  = int'(mm_addr);
            rd_left = int'(mm_burst);
            rd_cmds++;
        end
    end

    always @(posedge clk) begin
        wd_cnt++;
        if (wd_cnt == 150000) begin
            errors++;
            $display("FAIL watchdog: actual hang, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic csr_write(input logic [3:0] a, input logic [31:0] v);
        @(negedge clk);
        csr_wr = 1'b1; csr_addr = a; csr_wdata = v;
        @(negedge clk);
        csr_wr = 1'b0;
    endtask

    task automatic csr_read(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        csr_addr = a;
        #1 v = csr_rdata;
    endtask

    function automatic logic [31:0] m_first(int p, logic [31:0] sd);
        logic [31:0] m, r;
        m = (p == 1) ? 32'h7F : (p == 2) ? 32'h7FFF : (p == 3) ? 32'h7FFF_FFFF : 32'hFFFF_FFFF;
        r = sd & m;
        if (p >= 1 && p <= 3 && r == 0) r = 32'd1;
        return r;
    endfunction

    function automatic logic [31:0] m_next(int p, logic [31:0] s);
        case (p)
            1: return ((s << 1) & 32'h7F)        | (((s >> 6) ^ (s >> 5)) & 32'd1);
            2: return ((s << 1) & 32'h7FFF)      | (((s >> 14) ^ (s >> 13)) & 32'd1);
            3: return ((s << 1) & 32'h7FFF_FFFF) | (((s >> 30) ^ (s >> 27)) & 32'd1);
            4: return (s << 1) | (s >> 31);
            default: return s;
        endcase
    endfunction

    task automatic launch(input int p, input int wr, input int rd, input int b, input int stride,
                          input int loops, input logic [31:0] seed, input bit cont);
        csr_write(4'd7, p);
        csr_write(4'd3, wr);
        csr_write(4'd4, rd);
        csr_write(4'd5, b);
        csr_write(4'd6, stride);
        csr_write(4'd8, loops);
        csr_write(4'd9, seed);
        wr_bursts = 0; rd_cmds = 0; rb_idx = 0; wbeat = 0;
        csr_write(4'd1, {30'd0, cont, 1'b1});
    endtask

    task automatic wait_done();
        logic [31:0] v;
        for (int i = 0; i < 40000; i++) begin
            csr_read(4'd2, v);
            if (v[1]) break;
        end
    endtask

    task automatic mem_check(input string req, input int p, input int wr, input int b,
                             input int stride, input logic [31:0] seed);
        logic [31:0] st;
        int bad;
        st = m_first(p, seed);
        bad = 0;
        for (int t = 0; t < wr; t++)
            for (int k = 0; k < b; k++) begin
                if (mem[(t * stride * b + k) % 4096] !== st) bad++;
                st = m_next(p, st);
            end
        chk(req, "memory words differing from pattern/address model", bad, 0);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        csr_read(4'd0, v); chk("R1", "id word", v, 32'h7E57_0A01);
        csr_read(4'd3, v); chk("R1", "write count default", v, 1);
        csr_read(4'd4, v); chk("R1", "read count default", v, 1);
        csr_read(4'd5, v); chk("R1", "burst default", v, 1);
        csr_read(4'd6, v); chk("R1", "stride default", v, 1);
        csr_read(4'd7, v); chk("R1", "pattern default", v, 0);
        csr_read(4'd8, v); chk("R1", "loop default", v, 1);
        csr_read(4'd2, v); chk("R1", "status at reset", v, 0);
    endtask

    task automatic t_reject();
        logic [31:0] v;
        csr_write(4'd5, 3);  csr_read(4'd5, v); chk("R2", "burst 3 rejected", v, 1);
        csr_write(4'd5, 8);  csr_read(4'd5, v); chk("R2", "burst 8 taken", v, 8);
        csr_write(4'd5, 0);  csr_read(4'd5, v); chk("R2", "burst 0 rejected", v, 8);
        csr_write(4'd5, 32); csr_read(4'd5, v); chk("R2", "burst 32 rejected", v, 8);
        csr_write(4'd7, 3);  csr_write(4'd7, 5); csr_read(4'd7, v); chk("R4", "pattern 5 rejected", v, 3);
    endtask

    task automatic t_run(input string tag, input int p, input int wr, input int b,
                         input int stride, input int loops, input logic [31:0] seed, input bit wm);
        logic [31:0] v;
        wait_mode = wm;
        launch(p, wr, wr, b, stride, loops, seed, 1'b0);
        wait_done();
        wait_mode = 1'b0;
        mem_check({tag, " R3 R4 R10"}, p, wr, b, stride, seed);
        csr_read(4'd2, v); chk({tag, " R5 R7"}, "status", v, 32'd2);
        csr_read(4'd10, v); chk({tag, " R5"}, "mismatch count", v, 0);
        chk({tag, " R7"}, "write bursts", wr_bursts, wr * loops);
        chk({tag, " R7"}, "read bursts", rd_cmds, wr * loops);
    endtask

    task automatic t_first_fail();
        logic [31:0] v;
        corrupt_idx = 5;
        launch(0, 3, 3, 4, 2, 1, 32'h1234_5678, 1'b0);
        wait_done();
        corrupt_idx = -1;
        csr_read(4'd2, v);  chk("R6", "error flag set", v[2], 1);
        csr_read(4'd10, v); chk("R6", "single mismatch counted", v, 1);
        csr_read(4'd11, v); chk("R6", "first failing address", v, 9);
    endtask

    task automatic t_saturate_restart();
        logic [31:0] v;
        corrupt_all = 1'b1;
        launch(2, 20, 20, 16, 1, 1, 32'h0BAD_F00D, 1'b0);
        wait_done();
        corrupt_all = 1'b0;
        csr_read(4'd10, v); chk("R6", "mismatch count saturates", v, 255);
        csr_read(4'd11, v); chk("R6", "first failing address at 0", v, 0);
        launch(1, 4, 4, 4, 1, 1, 32'h0000_0033, 1'b0);
        csr_read(4'd2, v);  chk("R11", "start clears done and error", v, 32'd1);
        csr_read(4'd10, v); chk("R11", "start clears mismatch count", v, 0);
        wait_done();
        csr_read(4'd2, v);  chk("R11", "clean rerun status", v, 32'd2);
    endtask

    task automatic t_continuous();
        logic [31:0] v;
        int nl;
        launch(4, 2, 2, 2, 1, 1, 32'h8000_0001, 1'b1);
        for (int i = 0; i < 5000 && wr_bursts < 7; i++) @(negedge clk);
        csr_write(4'd1, 32'h2);
        wait_done();
        nl = wr_bursts / 2;
        chk("R8", "write bursts are whole loops", wr_bursts % 2, 0);
        chk("R8", "read bursts match completed loops", rd_cmds, nl * 2);
        chk("R8", "loop count ignored (more than 3 loops)", (nl > 3) ? 1 : 0, 1);
        csr_read(4'd2, v); chk("R8", "done and clean after stop", v, 32'd2);
    endtask

    task automatic t_cycles();
        logic [31:0] v, w;
        launch(0, 1, 1, 1, 1, 1, 32'h5, 1'b0);
        wait_done();
        csr_read(4'd12, v); chk("R9", "cycles of minimal run", v, 5);
        repeat (10) @(negedge clk);
        csr_read(4'd12, w); chk("R9", "cycles frozen when idle", w, v);
        launch(3, 8, 8, 16, 1, 1, 32'hDEAD_BEEF, 1'b0);
        wait_done();
        csr_read(4'd12, v); chk("R9", "long run counts more", (v > 32'd100) ? 1 : 0, 1);
        launch(0, 1, 1, 1, 1, 1, 32'h5, 1'b0);
        wait_done();
        csr_read(4'd12, v); chk("R9", "count restarts at start", v, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_reject();
        t_run("fixed",  0, 2, 1, 1, 1, 32'hCAFE_0001, 1'b0);
        t_run("prbs7",  1, 4, 4, 2, 1, 32'h0000_0000, 1'b0);
        t_run("prbs15", 2, 3, 2, 3, 2, 32'h0000_4321, 1'b1);
        t_run("prbs31", 3, 5, 16, 1, 1, 32'h1357_9BDF, 1'b0);
        t_run("rot1",   4, 3, 8, 2, 3, 32'h0000_0001, 1'b1);
        t_first_fail();
        t_saturate_restart();
        t_continuous();
        t_cycles();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule